// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block handles how a small 32-bit RISC core enters and leaves its exception handlers. The core drives one-cycle strobes when an instruction hits a breakpoint, when a load or store hits a data bus error, when an unsigned divide or remainder has a zero divisor, or when a system call executes. The block also watches a set of interrupt lines. It picks the winning event, computes the handler address, and raises a one-cycle redirect strobe with that address. In the same cycle it raises a write request so that the faulting PC is saved into the correct link register.

A small register set is reached through a select/write/read port. It holds the three-bit interrupt-enable register (IE), an interrupt mask, a write-one-to-clear pending register, and two handler base addresses: one for normal traps and one for debug traps. On entry, IE bit 0 is moved into a save slot, which is bit 1 for normal traps and bit 2 for debug traps, and the other bits are cleared. The two return strobes put the saved bit back into bit 0. The register file, the instruction decode and the divider itself are outside the block.

Top module: `trap_unit`

## Requirements
- R1: During and after synchronous reset, every register reads zero and `redir_valid`, `save_exc_we` and `save_brk_we` are low.
- R2: A normal trap redirects to the normal base plus 32 times its cause code. The cause codes are data bus error 4, divide-by-zero 5, interrupt 6 and system call 7. `redir_valid`, `redir_pc` and `redir_cause` appear one clock after the strobe.
- R3: A breakpoint redirects to the debug base plus 32, with cause code 1. The normal base is not used.
- R4: On a normal trap, IE becomes {0, old bit 0, 0}, with bit 2 first.
- R5: On a breakpoint, IE becomes {old bit 0, 0, 0}, with bit 2 first.
- R6: `ret_exc` loads IE with {0, 0, old bit 1}. `ret_brk` loads IE with {0, 0, old bit 2}. When both are asserted, `ret_exc` wins.
- R7: The select codes are 0 IE, 1 mask, 2 pending, 3 normal base and 4 debug base. A write to pending clears each bit written 1 and keeps each bit written 0. Interrupt lines set pending bits every cycle, and a set wins over a clear in the same cycle. Writes to the other registers replace them. Both bases always read with bits 7:0 at zero. A write with codes 5 to 7 changes nothing, and a read with those codes returns zero.
- R8: A `div_op` with a zero `divisor` raises divide-by-zero and holds `div_wr_en` low. A `div_op` with a nonzero divisor drives `div_wr_en` high and raises no trap.
- R9: A normal trap pulses `save_exc_we` and a breakpoint pulses `save_brk_we`, in the redirect cycle, with `save_pc` equal to `cur_pc` from the strobe cycle. The two are never high together.
- R10: An interrupt is taken only when IE bit 0 is set and pending AND mask is nonzero.
- R11: When several events occur in the same cycle, the priority is breakpoint, then data bus error, then divide-by-zero, then system call, then interrupt. An entry overrides a same-cycle return or IE write.
- R12: A single strobe gives a `redir_valid` pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | PC of the instruction raising the event |
| ev_brk | input | 1 | Breakpoint strobe |
| ev_dbus | input | 1 | Data bus error strobe (unmapped or misaligned access) |
| ev_scall | input | 1 | System call strobe |
| div_op | input | 1 | Unsigned divide/remainder in execute |
| divisor | input | 32 | Divisor operand of that operation |
| div_wr_en | output | 1 | Destination write permitted for the divide |
| irq_lines | input | 8 | Interrupt request lines |
| ret_exc | input | 1 | Return from normal trap |
| ret_brk | input | 1 | Return from breakpoint |
| csr_we | input | 1 | Register write enable |
| csr_sel | input | 3 | Register select code |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Handler address |
| redir_cause | output | 3 | Cause code of the redirect |
| save_exc_we | output | 1 | Write faulting PC into the exception link register |
| save_brk_we | output | 1 | Write faulting PC into the breakpoint link register |
| save_pc | output | 32 | PC to be saved |

## Verification
The bench tries every IE value with every synchronous event, and every combination of those events fired together. This catches a swapped save slot, a breakpoint that uses the normal base, and a priority inversion. Each of these would show up as a wrong IE readback or a wrong `redir_pc` or cause. The return tests use IE patterns in which bit 1 and bit 2 differ, so a return that restores from the wrong slot, or a wrong winner when both return strobes are set, gives a wrong bit 0. The pending tests cover clearing with ones and with zeros, a set and a clear in the same cycle, and the interrupt gate with IE bit 0 clear or the mask empty. A design that treated pending as a plain register, or ignored the enable, would take or lose an interrupt at the wrong time.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN      = 32;
    localparam int IE_W      = 3;
    localparam int SEL_W     = 3;
    localparam int VEC_SHIFT = 5;
    localparam int BASE_LSB  = 8;
    localparam int ID_W      = 3;

    typedef enum logic [ID_W-1:0] {
        CAUSE_RESET = 3'd0,
        CAUSE_BREAK = 3'd1,
        CAUSE_IBUS  = 3'd2,
        CAUSE_WATCH = 3'd3,
        CAUSE_DBUS  = 3'd4,
        CAUSE_DIVZ  = 3'd5,
        CAUSE_IRQ   = 3'd6,
        CAUSE_SCALL = 3'd7
    } cause_e;

    typedef enum logic [SEL_W-1:0] {
        REG_IE   = 3'd0,
        REG_MASK = 3'd1,
        REG_PEND = 3'd2,
        REG_BASE = 3'd3,
        REG_DBASE = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic   take;
        logic   dbg;
        cause_e id;
    } trap_req_t;

    // Source index in priority order: lower index wins.
    localparam int NSRC = 5;

    function automatic cause_e src_cause(input int idx);
        case (idx)
            0:       return CAUSE_BREAK;
            1:       return CAUSE_DBUS;
            2:       return CAUSE_DIVZ;
            3:       return CAUSE_SCALL;
            default: return CAUSE_IRQ;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] vec_addr(input logic [XLEN-1:0] base,
                                                 input cause_e id);
        logic [XLEN-1:0] off;
        off = {{(XLEN-ID_W){1'b0}}, id} << VEC_SHIFT;
        return base + off;
    endfunction

    function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] v);
        return {v[XLEN-1:BASE_LSB], {BASE_LSB{1'b0}}};
    endfunction

    function automatic logic [IE_W-1:0] ie_on_entry(input logic [IE_W-1:0] ie,
                                                    input logic dbg);
        logic [IE_W-1:0] r;
        r = '0;
        if (dbg) r[2] = ie[0];
        else     r[1] = ie[0];
        return r;
    endfunction

    function automatic logic [IE_W-1:0] ie_on_return(input logic [IE_W-1:0] ie,
                                                     input logic dbg);
        logic [IE_W-1:0] r;
        r    = '0;
        r[0] = dbg ? ie[2] : ie[1];
        return r;
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic      hit_brk,
    input  logic      hit_dbus,
    input  logic      hit_divz,
    input  logic      hit_scall,
    input  logic      hit_irq,
    output trap_req_t req
);

    logic [NSRC-1:0] hits;

    assign hits = {hit_irq, hit_scall, hit_divz, hit_dbus, hit_brk};

    always_comb begin
        req.take = 1'b0;
        req.dbg  = 1'b0;
        req.id   = CAUSE_RESET;
        // Walk from lowest priority up so the highest-priority hit lands last.
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hits[i]) begin
                req.take = 1'b1;
                req.id   = src_cause(i);
                req.dbg  = (src_cause(i) == CAUSE_BREAK);
            end
        end
    end

endmodule

// File: rtl/trap_csr.sv
module trap_csr
    import trap_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [SEL_W-1:0] csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    input  logic [NIRQ-1:0]  irq_lines,
    input  trap_req_t        req,
    input  logic             ret_exc,
    input  logic             ret_brk,
    output logic [IE_W-1:0]  ie_q,
    output logic [XLEN-1:0]  base_q,
    output logic [XLEN-1:0]  dbase_q,
    output logic             irq_hit
);

    reg_sel_e        sel;
    logic [NIRQ-1:0] mask_q;
    logic [NIRQ-1:0] pend_q;
    logic [NIRQ-1:0] pend_clr;
    logic [IE_W-1:0] ie_d;

    assign sel = reg_sel_e'(csr_sel);

    assign pend_clr = (csr_we && sel == REG_PEND) ? csr_wdata[NIRQ-1:0] : '0;

    always_comb begin
        if (req.take)
            ie_d = ie_on_entry(ie_q, req.dbg);
        else if (ret_exc)
            ie_d = ie_on_return(ie_q, 1'b0);
        else if (ret_brk)
            ie_d = ie_on_return(ie_q, 1'b1);
        else if (csr_we && sel == REG_IE)
            ie_d = csr_wdata[IE_W-1:0];
        else
            ie_d = ie_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q    <= '0;
            mask_q  <= '0;
            pend_q  <= '0;
            base_q  <= '0;
            dbase_q <= '0;
        end else begin
            ie_q   <= ie_d;
            pend_q <= (pend_q & ~pend_clr) | irq_lines;
            if (csr_we && sel == REG_MASK)  mask_q  <= csr_wdata[NIRQ-1:0];
            if (csr_we && sel == REG_BASE)  base_q  <= align_base(csr_wdata);
            if (csr_we && sel == REG_DBASE) dbase_q <= align_base(csr_wdata);
        end
    end

    always_comb begin
        case (sel)
            REG_IE:    csr_rdata = {{(XLEN-IE_W){1'b0}}, ie_q};
            REG_MASK:  csr_rdata = {{(XLEN-NIRQ){1'b0}}, mask_q};
            REG_PEND:  csr_rdata = {{(XLEN-NIRQ){1'b0}}, pend_q};
            REG_BASE:  csr_rdata = base_q;
            REG_DBASE: csr_rdata = dbase_q;
            default:   csr_rdata = '0;
        endcase
    end

    assign irq_hit = ie_q[0] && (|(pend_q & mask_q));

endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
    import trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  trap_req_t       req,
    input  logic [XLEN-1:0] base_q,
    input  logic [XLEN-1:0] dbase_q,
    input  logic [XLEN-1:0] cur_pc,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic [ID_W-1:0] redir_cause,
    output logic            save_exc_we,
    output logic            save_brk_we,
    output logic [XLEN-1:0] save_pc
);

    logic [XLEN-1:0] target;

    assign target = vec_addr(req.dbg ? dbase_q : base_q, req.id);

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_cause <= '0;
            save_exc_we <= 1'b0;
            save_brk_we <= 1'b0;
            save_pc     <= '0;
        end else begin
            redir_valid <= req.take;
            save_exc_we <= req.take && !req.dbg;
            save_brk_we <= req.take && req.dbg;
            if (req.take) begin
                redir_pc    <= target;
                redir_cause <= req.id;
                save_pc     <= cur_pc;
            end
        end
    end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int NIRQ = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cur_pc,
    input  logic        ev_brk,
    input  logic        ev_dbus,
    input  logic        ev_scall,
    input  logic        div_op,
    input  logic [31:0] divisor,
    output logic        div_wr_en,
    input  logic [NIRQ-1:0] irq_lines,
    input  logic        ret_exc,
    input  logic        ret_brk,
    input  logic        csr_we,
    input  logic [2:0]  csr_sel,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        redir_valid,
    output logic [31:0] redir_pc,
    output logic [2:0]  redir_cause,
    output logic        save_exc_we,
    output logic        save_brk_we,
    output logic [31:0] save_pc
);

    trap_req_t       req;
    logic            divz_hit;
    logic            irq_hit;
    logic [IE_W-1:0] ie_q;
    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] dbase_q;

    assign divz_hit  = div_op && (divisor == '0);
    assign div_wr_en = div_op && !divz_hit;

    trap_arbiter u_arb (
        .hit_brk   (ev_brk),
        .hit_dbus  (ev_dbus),
        .hit_divz  (divz_hit),
        .hit_scall (ev_scall),
        .hit_irq   (irq_hit),
        .req       (req)
    );

    trap_csr #(.NIRQ(NIRQ)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .irq_lines (irq_lines),
        .req       (req),
        .ret_exc   (ret_exc),
        .ret_brk   (ret_brk),
        .ie_q      (ie_q),
        .base_q    (base_q),
        .dbase_q   (dbase_q),
        .irq_hit   (irq_hit)
    );

    trap_redirect u_redir (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .base_q      (base_q),
        .dbase_q     (dbase_q),
        .cur_pc      (cur_pc),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .redir_cause (redir_cause),
        .save_exc_we (save_exc_we),
        .save_brk_we (save_brk_we),
        .save_pc     (save_pc)
    );

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        ev_brk,
    input logic        ev_dbus,
    input logic        ev_scall,
    input logic        div_op,
    input logic [31:0] divisor,
    input logic        redir_valid,
    input logic [7:0]  redir_pc_lo,
    input logic [2:0]  redir_cause,
    input logic        save_exc_we,
    input logic        save_brk_we,
    input logic [2:0]  ie_q,
    input logic [2:0]  csr_sel,
    input logic [7:0]  rdata_lo
);

    logic sync_ev;
    assign sync_ev = ev_brk || ev_dbus || ev_scall || (div_op && divisor == 32'd0);

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !sync_ev) |=> !redir_valid);

    // R9
    save_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({save_exc_we, save_brk_we}) && ((save_exc_we || save_brk_we) == redir_valid));

    // R3
    debug_vector_chk: assert property (@(posedge clk) disable iff (rst)
        save_brk_we |-> (redir_cause == 3'd1 && redir_pc_lo == 8'h20));

    // R2
    vector_align_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (redir_pc_lo[4:0] == 5'd0));

    // R4
    exc_ie_save_chk: assert property (@(posedge clk) disable iff (rst)
        save_exc_we |-> (ie_q == {1'b0, $past(ie_q[0]), 1'b0}));

    // R5
    brk_ie_save_chk: assert property (@(posedge clk) disable iff (rst)
        save_brk_we |-> (ie_q == {$past(ie_q[0]), 2'b00}));

    // R8
    divz_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (div_op && divisor == 32'd0 && !ev_brk && !ev_dbus) |=> (redir_valid && redir_cause == 3'd5));

    // R7
    base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 3'd3 || csr_sel == 3'd4) |-> (rdata_lo == 8'h00));

endmodule

bind trap_unit trap_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_brk      (ev_brk),
    .ev_dbus     (ev_dbus),
    .ev_scall    (ev_scall),
    .div_op      (div_op),
    .divisor     (divisor),
    .redir_valid (redir_valid),
    .redir_pc_lo (redir_pc[7:0]),
    .redir_cause (redir_cause),
    .save_exc_we (save_exc_we),
    .save_brk_we (save_brk_we),
    .ie_q        (ie_q),
    .csr_sel     (csr_sel),
    .rdata_lo    (csr_rdata[7:0])
);

// File: tb/test_trap_unit.sv
`timescale 1ns/1ps
module test_trap_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cur_pc;
    logic        ev_brk, ev_dbus, ev_scall, div_op;
    logic [31:0] divisor;
    logic        div_wr_en;
    logic [7:0]  irq_lines;
    logic        ret_exc, ret_brk, csr_we;
    logic [2:0]  csr_sel;
    logic [31:0] csr_wdata, csr_rdata;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic [2:0]  redir_cause;
    logic        save_exc_we, save_brk_we;
    logic [31:0] save_pc;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trap_unit i_trap_unit (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .ev_brk(ev_brk), .ev_dbus(ev_dbus),
        .ev_scall(ev_scall), .div_op(div_op), .divisor(divisor), .div_wr_en(div_wr_en),
        .irq_lines(irq_lines), .ret_exc(ret_exc), .ret_brk(ret_brk), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_cause(redir_cause),
        .save_exc_we(save_exc_we), .save_brk_we(save_brk_we), .save_pc(save_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        ev_brk = 0; ev_dbus = 0; ev_scall = 0; div_op = 0; divisor = 32'd1;
        irq_lines = '0; ret_exc = 0; ret_brk = 0; csr_we = 0; csr_sel = 3'd0;
        csr_wdata = '0; cur_pc = '0;
    endtask

    task automatic csr_wr(input logic [2:0] s, input logic [31:0] d);
        csr_we = 1; csr_sel = s; csr_wdata = d;
        cyc();
        csr_we = 0;
    endtask

    task automatic csr_rd(input logic [2:0] s, output logic [31:0] d);
        csr_we = 0; csr_sel = s;
        #0.5;
        d = csr_rdata;
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [31:0] rd;
        idle_in();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        // R1 state while reset is held
        chk("R1", "redir_valid in reset", {31'd0, redir_valid}, 32'd0);
        rst = 0;
        for (int s = 0; s < 5; s++) begin
            csr_rd(s[2:0], rd);
            chk("R1", "reg after reset", rd, 32'd0);
        end
        chk("R1", "save strobes", {30'd0, save_exc_we, save_brk_we}, 32'd0);

        // R7 base alignment and replace
        csr_wr(3'd3, 32'h1234_56FF);
        csr_rd(3'd3, rd);
        chk("R7", "base masked", rd, 32'h1234_5600);
        csr_wr(3'd4, 32'hCAFE_F00D);
        csr_rd(3'd4, rd);
        chk("R7", "dbase masked", rd, 32'hCAFE_F000);

        // R8 nonzero divisor: write allowed, no trap
        div_op = 1; divisor = 32'd7;
        #0.5;
        chk("R8", "div_wr_en nonzero", {31'd0, div_wr_en}, 32'd1);
        cyc();
        div_op = 0;
        chk("R8", "no redirect nonzero", {31'd0, redir_valid}, 32'd0);
        div_op = 1; divisor = 32'd0;
        #0.5;
        chk("R8", "div_wr_en zero", {31'd0, div_wr_en}, 32'd0);
        cyc();
        div_op = 0; divisor = 32'd1;
        chk("R8", "divz redirect", {29'd0, redir_cause}, 32'd5);
        cyc();

        // Sweep: every IE value with every synchronous event (R2 R3 R4 R5 R9 R12)
        for (int v = 0; v < 8; v++) begin
            for (int e = 0; e < 4; e++) begin
                logic [31:0] bw, dw, pc, exp_pc, exp_ie;
                int id;
                bit dbg;
                bw = (32'h1000_0000 * (v + 1)) | 32'h3C5;
                dw = (32'h0800_0000 * (v + 2)) | 32'h0A7;
                csr_wr(3'd3, bw);
                csr_wr(3'd4, dw);
                csr_wr(3'd0, v);
                pc = 32'h0000_1000 + v * 16 + e * 4;
                cur_pc = pc;
                dbg = (e == 0);
                case (e)
                    0: begin ev_brk = 1; id = 1; end
                    1: begin ev_dbus = 1; id = 4; end
                    2: begin div_op = 1; divisor = 0; id = 5; end
                    default: begin ev_scall = 1; id = 7; end
                endcase
                cyc();
                idle_in();
                exp_pc = (dbg ? (dw & 32'hFFFF_FF00) : (bw & 32'hFFFF_FF00)) + id * 32;
                exp_ie = dbg ? ((v & 1) << 2) : ((v & 1) << 1);
                chk("R12", "redir_valid rise", {31'd0, redir_valid}, 32'd1);
                chk(dbg ? "R3" : "R2", "redir_pc", redir_pc, exp_pc);
                chk(dbg ? "R3" : "R2", "redir_cause", {29'd0, redir_cause}, id);
                chk("R9", "save strobes", {30'd0, save_exc_we, save_brk_we},
                    dbg ? 32'd1 : 32'd2);
                chk("R9", "save_pc", save_pc, pc);
                csr_rd(3'd0, rd);
                chk(dbg ? "R5" : "R4", "IE after entry", rd, exp_ie);
                cyc();
                chk("R12", "redir_valid fall", {31'd0, redir_valid}, 32'd0);
            end
        end

        // R6 returns
        csr_wr(3'd0, 32'd2); ret_exc = 1; cyc(); ret_exc = 0;
        csr_rd(3'd0, rd); chk("R6", "ret_exc from 010", rd, 32'd1);
        csr_wr(3'd0, 32'd4); ret_exc = 1; cyc(); ret_exc = 0;
        csr_rd(3'd0, rd); chk("R6", "ret_exc from 100", rd, 32'd0);
        csr_wr(3'd0, 32'd4); ret_brk = 1; cyc(); ret_brk = 0;
        csr_rd(3'd0, rd); chk("R6", "ret_brk from 100", rd, 32'd1);
        csr_wr(3'd0, 32'd2); ret_brk = 1; cyc(); ret_brk = 0;
        csr_rd(3'd0, rd); chk("R6", "ret_brk from 010", rd, 32'd0);
        csr_wr(3'd0, 32'd4); ret_exc = 1; ret_brk = 1; cyc(); ret_exc = 0; ret_brk = 0;
        csr_rd(3'd0, rd); chk("R6", "both returns exc wins", rd, 32'd0);

        // R11 priority over all combinations of synchronous events
        csr_wr(3'd3, 32'h8000_0000);
        csr_wr(3'd4, 32'h9000_0000);
        for (int m = 0; m < 16; m++) begin
            int id;
            csr_wr(3'd0, 32'd1);
            ev_brk = m[0]; ev_dbus = m[1]; ev_scall = m[3];
            div_op = m[2]; divisor = m[2] ? 32'd0 : 32'd1;
            cur_pc = 32'h2000 + m * 4;
            cyc();
            idle_in();
            if (m[0]) id = 1; else if (m[1]) id = 4; else if (m[2]) id = 5;
            else if (m[3]) id = 7; else id = 0;
            chk("R11", "valid", {31'd0, redir_valid}, (m != 0) ? 32'd1 : 32'd0);
            if (m != 0) begin
                chk("R11", "cause", {29'd0, redir_cause}, id);
                chk("R11", "pc", redir_pc,
                    ((id == 1) ? 32'h9000_0000 : 32'h8000_0000) + id * 32);
            end
            cyc();
        end

        // R11 entry beats same-cycle IE write and return
        csr_wr(3'd0, 32'd1);
        ev_scall = 1; csr_we = 1; csr_sel = 3'd0; csr_wdata = 32'd7;
        cyc(); idle_in();
        csr_rd(3'd0, rd); chk("R11", "entry beats IE write", rd, 32'd2);
        cyc();
        csr_wr(3'd0, 32'd1);
        ev_scall = 1; ret_exc = 1;
        cyc(); idle_in();
        csr_rd(3'd0, rd); chk("R11", "entry beats return", rd, 32'd2);
        cyc();

        // R7 pending register
        csr_wr(3'd0, 32'd0);
        irq_lines = 8'hA5; cyc(); irq_lines = 8'h00;
        csr_rd(3'd2, rd); chk("R7", "pending latched", rd, 32'hA5);
        csr_wr(3'd2, 32'h21);
        csr_rd(3'd2, rd); chk("R7", "W1C ones", rd, 32'h84);
        csr_wr(3'd2, 32'h00);
        csr_rd(3'd2, rd); chk("R7", "W1C zeros keep", rd, 32'h84);
        irq_lines = 8'h01; csr_wr(3'd2, 32'h01); irq_lines = 8'h00;
        csr_rd(3'd2, rd); chk("R7", "set wins clear", rd, 32'h85);
        csr_wr(3'd2, 32'h01);
        csr_rd(3'd2, rd); chk("R7", "clear bit 0", rd, 32'h84);

        // R10 interrupt gate
        csr_wr(3'd0, 32'd1);
        cyc();
        chk("R10", "no irq with empty mask", {31'd0, redir_valid}, 32'd0);
        csr_wr(3'd0, 32'd0);
        csr_wr(3'd1, 32'h80);
        cyc();
        chk("R10", "no irq with IE0 clear", {31'd0, redir_valid}, 32'd0);
        csr_wr(3'd0, 32'd1);
        chk("R10", "not yet taken", {31'd0, redir_valid}, 32'd0);
        cyc();
        chk("R10", "irq taken", {31'd0, redir_valid}, 32'd1);
        chk("R2", "irq cause", {29'd0, redir_cause}, 32'd6);
        chk("R2", "irq pc", redir_pc, 32'h8000_0000 + 6 * 32);
        csr_rd(3'd0, rd); chk("R4", "IE after irq", rd, 32'd2);
        cyc();
        chk("R12", "irq single pulse", {31'd0, redir_valid}, 32'd0);

        // R7 unused select codes
        csr_wr(3'd5, 32'hFFFF_FFFF);
        csr_wr(3'd7, 32'hFFFF_FFFF);
        csr_rd(3'd5, rd); chk("R7", "sel5 reads zero", rd, 32'd0);
        csr_rd(3'd1, rd); chk("R7", "mask untouched", rd, 32'h80);
        csr_rd(3'd3, rd); chk("R7", "base untouched", rd, 32'h8000_0000);
        csr_rd(3'd0, rd); chk("R7", "IE untouched", rd, 32'd2);

        done = 1;
        finish_up();
    end

endmodule